// File: doc/BRIEF.md
# I2C interrupt vector prioritizer

This block sits beside an I2C bus engine and turns its single-cycle event pulses into interrupt state that software can service. Each of seven event kinds latches a sticky flag in a status word. A mask word selects which flags may raise the interrupt request. A vector register reports a 3-bit code for the most urgent flag that is both pending and enabled.

Reading the vector acknowledges the event it names. That flag drops at the same clock edge, so the next read already shows the next pending event. An interrupt handler can loop on vector reads until it gets zero, with no bitmap decoding. Flags may also be cleared directly by writing ones to the status word. Two level inputs, bus busy and receive-shift full, are mirrored into the status word for polling only.

The register port is a plain control strobe interface (`reg_wr_i`, `reg_rd_i`) with no back-pressure. Read data is combinational from the addressed register while `reg_rd_i` is high, and any read side effect happens at the clock edge that ends that cycle. Address map: 0 mask, 1 status, 2 vector, 3 unmapped.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the mask, status and vector registers all read 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k at the next edge, whether or not it is masked. The bit assignment is: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: The mask register (address 0) stores write-data bits 6:0, one enable per status bit of the same position; bits 15:7 always read 0.
- R4: The vector register (address 2) reads k+1 for the lowest k whose status bit and mask bit are both 1, giving codes 1 to 7. It reads 0 when no such bit exists.
- R5: A vector read that returns a nonzero code clears exactly that status bit at the edge ending the read. Masked flags stay set. A read returning 0 changes nothing.
- R6: Writing the status register (address 1) clears each of bits 6:0 where write data holds a 1; zeros leave bits unchanged.
- R7: Status bit 12 shows `bus_busy_i` and bit 11 shows `rx_full_i`, each delayed by one cycle. Writes cannot clear them, and they never affect the vector or `irq_o`.
- R8: An event pulse in the same cycle as a clear of its bit, by status write or by vector read, leaves the bit set.
- R9: `irq_o` is high exactly when some status bit in 6:0 and its mask bit are both 1.
- R10: Writes to address 2 or 3 change no state, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses, bit positions as in R2 |
| bus_busy_i | input | 1 | Bus busy level |
| rx_full_i | input | 1 | Receive-shift full level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (vector read acknowledges) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every event pattern under a full mask, every mask under all events pending, and a spread of mixed pairs. For each case it predicts the complete sequence of vector codes down to zero. A priority encoder picking the wrong end would return the codes in reverse order. An acknowledge that cleared the wrong bit, or cleared masked flags, would repeat a code or leave a residue in the status word.

The races are forced directly: an event arriving in the very cycle its flag is cleared must survive. A design giving the clear priority would silently lose that event. The level bits are written with ones to catch a design that treats them as clearable flags, and writes to the vector and unmapped addresses are checked to leave the mask and status untouched.

// File: rtl/i2c_ivp_pkg.sv
package i2c_ivp_pkg;
  localparam int ADR_MASK = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_VEC  = 2;
endpackage

// File: rtl/i2c_ivp_flags.sv
module i2c_ivp_flags #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] flags_o
);
  // set wins over clear so a coincident event is never lost
  always_ff @(posedge clk) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (flags_o & ~clr_i) | evt_i;
  end

  // R2 and R8: every pulsed event is latched, even against a clear
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  // R6: cleared bits without a new event drop
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~evt_i)) |=> ((flags_o & $past(clr_i & ~evt_i)) == '0));

  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/i2c_ivp_pick.sv
module i2c_ivp_pick #(
  parameter int NUM_EVT = 7,
  parameter int CODE_W  = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] pend_i,
  output logic [NUM_EVT-1:0] grant_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_EVT-1:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  for (g = 0; g < NUM_EVT; g++) begin : g_rank
    assign grant_o[g] = pend_i[g] & ~seen[g];
    if (g < NUM_EVT - 1) begin : g_chain
      assign seen[g+1] = seen[g] | pend_i[g];
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (grant_o[i]) code_o = CODE_W'(i + 1);
    end
  end

  // R4: at most one winner, and the code names a pending event
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r4_code_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != '0) |-> pend_i[int'(code_o) - 1]);
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_ivp_pkg::*;
#(
  parameter int NUM_EVT  = 7,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int RXF_BIT  = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_busy_i,
  input  logic               rx_full_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int CODE_W = $clog2(NUM_EVT + 1);

  logic [NUM_EVT-1:0] mask_q, flags, pend, grant, clr;
  logic [CODE_W-1:0]  code;
  logic               busy_q, rxf_q;
  logic               sel_mask, sel_stat, sel_vec;
  logic               rd_vec;
  logic [DATA_W-1:0]  stat_word;

  assign sel_mask = (reg_addr_i == ADDR_W'(ADR_MASK));
  assign sel_stat = (reg_addr_i == ADDR_W'(ADR_STAT));
  assign sel_vec  = (reg_addr_i == ADDR_W'(ADR_VEC));
  assign rd_vec   = reg_rd_i && !reg_wr_i && sel_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      busy_q <= 1'b0;
      rxf_q  <= 1'b0;
    end else begin
      busy_q <= bus_busy_i;
      rxf_q  <= rx_full_i;
      if (reg_wr_i && sel_mask) mask_q <= reg_wdata_i[NUM_EVT-1:0];
    end
  end

  assign clr = ((reg_wr_i && sel_stat) ? reg_wdata_i[NUM_EVT-1:0] : '0)
             | (rd_vec ? grant : '0);

  i2c_ivp_flags #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .flags_o(flags)
  );

  assign pend = flags & mask_q;

  i2c_ivp_pick #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .grant_o(grant),
    .code_o (code)
  );

  assign irq_o = |pend;

  always_comb begin
    stat_word = '0;
    stat_word[NUM_EVT-1:0] = flags;
    stat_word[RXF_BIT]     = rxf_q;
    stat_word[BUSY_BIT]    = busy_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_mask)      reg_rdata_o[NUM_EVT-1:0] = mask_q;
    else if (sel_stat) reg_rdata_o = stat_word;
    else if (sel_vec)  reg_rdata_o[CODE_W-1:0] = code;
  end

  // R9: request line agrees with the vector encoder
  a_r9_irq_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (code != '0));

  // R5: an acknowledged event is gone next cycle unless it re-fired
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && code != '0) |=> ((flags & $past(grant & ~evt_i)) == '0));
endmodule

// File: tb/i2c_irq_vector_bench.sv
module i2c_irq_vector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0, rxf = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  logic [15:0] d;

  always #10 clk = ~clk;

  i2c_irq_vector u_i2c_irq_vector (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_busy_i(busy), .rx_full_i(rxf),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 v = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(posedge clk); #1 evt = '0;
  endtask

  function automatic logic [15:0] lowest(input logic [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  task automatic run_case(input logic [6:0] pat, input logic [6:0] msk);
    logic [6:0]  pend;
    logic [15:0] v, e;
    wr_reg(2'd0, {9'd0, msk});
    wr_reg(2'd1, 16'h007F);
    pulse(pat);
    rd_reg(2'd1, v);
    chk("R2 status after events", v, {9'd0, pat});
    chk("R9 irq pending", {15'd0, irq}, {15'd0, |(pat & msk)});
    pend = pat & msk;
    for (int k = 0; k < 8; k++) begin
      rd_reg(2'd2, v);
      e = lowest(pend);
      chk("R4 R5 vector sequence", v, e);
      if (e == 16'd0) break;
      pend[e - 1] = 1'b0;
    end
    rd_reg(2'd1, v);
    chk("R5 masked flags remain", v, {9'd0, pat & ~msk});
    chk("R9 irq after drain", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_reg(2'd0, d); chk("R1 mask reset", d, 16'h0);
    rd_reg(2'd1, d); chk("R1 status reset", d, 16'h0);
    rd_reg(2'd2, d); chk("R1 vector reset", d, 16'h0);
    chk("R1 irq reset", {15'd0, irq}, 16'h0);

    // R3 mask width
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, d); chk("R3 mask readback", d, 16'h007F);

    // sweeps over patterns and masks
    for (int p = 0; p < 128; p++) run_case(7'(p), 7'h7F);
    for (int m = 0; m < 128; m++) run_case(7'h7F, 7'(m));
    for (int i = 0; i < 128; i++) run_case(7'(i * 37), 7'(i * 91 + 5));

    // R6 write-one-to-clear
    wr_reg(2'd0, 16'h0);
    pulse(7'h7F);
    wr_reg(2'd1, 16'h0015);
    rd_reg(2'd1, d); chk("R6 w1c selected bits", d, 16'h006A);
    wr_reg(2'd1, 16'h0000);
    rd_reg(2'd1, d); chk("R6 zero write no effect", d, 16'h006A);
    wr_reg(2'd1, 16'h007F);

    // R8 event coincident with status write clear
    @(negedge clk); addr = 2'd1; wdata = 16'h0004; wr = 1'b1; evt = 7'h04;
    @(posedge clk); #1 wr = 1'b0; evt = '0;
    rd_reg(2'd1, d); chk("R8 event beats w1c", d, 16'h0004);

    // R8 event coincident with vector acknowledge
    wr_reg(2'd0, 16'h007F);
    @(negedge clk); addr = 2'd2; rd = 1'b1; evt = 7'h04;
    #2 d = rdata; chk("R4 vector access ready code", d, 16'd3);
    @(posedge clk); #1 rd = 1'b0; evt = '0;
    rd_reg(2'd1, d); chk("R8 event beats ack", d, 16'h0004);
    rd_reg(2'd2, d); chk("R5 ack reads code again", d, 16'd3);
    rd_reg(2'd2, d); chk("R5 drained to zero", d, 16'd0);
    rd_reg(2'd1, d); chk("R5 zero read no effect", d, 16'h0000);

    // R7 level bits
    @(negedge clk); busy = 1'b1; rxf = 1'b1;
    @(posedge clk);
    rd_reg(2'd1, d); chk("R7 level bits shown", d, 16'h1800);
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, d); chk("R7 level bits not cleared", d, 16'h1800);
    rd_reg(2'd2, d); chk("R7 levels not in vector", d, 16'd0);
    chk("R7 levels not in irq", {15'd0, irq}, 16'h0);
    @(negedge clk); busy = 1'b0;
    @(posedge clk);
    rd_reg(2'd1, d); chk("R7 busy follows input", d, 16'h0800);
    @(negedge clk); rxf = 1'b0;
    @(posedge clk);

    // R10 writes to vector and unmapped addresses
    wr_reg(2'd0, 16'h0055);
    pulse(7'h7F);
    wr_reg(2'd2, 16'hFFFF);
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd0, d); chk("R10 mask untouched", d, 16'h0055);
    rd_reg(2'd1, d); chk("R10 status untouched", d, 16'h007F);
    rd_reg(2'd3, d); chk("R10 unmapped reads zero", d, 16'h0000);
    rd_reg(2'd2, d); chk("R4 vector after R10", d, 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule